// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block holds the digital control for a three-phase integrating converter. A free-running divider turns the input clock into count ticks, one tick per four clocks. On those ticks the block steps through a measurement cycle of fixed length: auto-zero, signal integrate, then reference de-integrate, and back to auto-zero. While each phase runs, the block drives one analog switch-control line. The integrator, the comparator and the references sit outside the block. The block sees them only through one comparator bit, which reads high while the integrator output is above zero.

At the last integrate tick the comparator bit gives the input sign. That sign decides which reference switch closes for de-integration. De-integrate ticks are counted in chained decade counters. The phase ends at the first tick on which the comparator shows that the integrator has crossed back through zero, or at a count limit, which flags overrange. The cycle total never changes, so auto-zero takes whatever de-integrate time is left over. One tick with every switch open separates each pair of neighbouring phases, and that time is also taken from auto-zero. One clock after de-integration stops, a one-clock strobe presents the BCD reading, the sign and the overrange flag.

Top module: `dsadc_seq`

## Requirements
- R1: While reset is asserted and immediately after it is released, all four switch outputs, `rd_stb_o`, `rd_bcd_o`, `rd_neg_o` and `rd_ovr_o` are low. The first cycle opens with one all-open count and then enters integrate.
- R2: One count lasts 4 clocks. `sw_int_o` stays high for exactly 1000 counts (4000 clocks) in every cycle.
- R3: Switch activity follows a fixed order: integrate, then one de-integrate switch, then auto-zero, then integrate again.
- R4: At most one switch output is high at any time. Every change of phase passes through exactly one count (4 clocks) with all four switch outputs low.
- R5: The cycle length is fixed at 4000 counts, so successive rises of `sw_int_o` are 16000 clocks apart. For a reading N below 2000, auto-zero lasts 2996-N counts. After an overrange it lasts 997 counts.
- R6: `cmp_i` is sampled at the last integrate tick. A high value selects `sw_dip_o` and a later `rd_neg_o` of 0. A low value selects `sw_din_o` and a later `rd_neg_o` of 1. The sign and the selected switch do not change during de-integrate.
- R7: De-integrate ends at the first count tick on which `cmp_i` equals `rd_neg`'s latched sign value (low for a positive input, high for a negative one). The reading is the number of whole counts before that tick. `rd_bcd_o` carries it as four BCD digits, with the units in bits [3:0], tens in [7:4], hundreds in [11:8] and thousands in [15:12].
- R8: If no crossing has been seen after 2000 de-integrate counts, de-integrate stops, `rd_ovr_o` is 1 and `rd_bcd_o` reads 16'h2000. Otherwise `rd_ovr_o` is 0.
- R9: If the crossing is first seen on the tick at which the 2000-count limit is reached, the crossing takes priority: the reading is 1999 and `rd_ovr_o` is 0.
- R10: `rd_stb_o` is a single-clock pulse, issued once per cycle, one clock after the de-integrate switch opens. It arrives together with the new reading, sign and overrange values, and these hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_i | input | 1 | Comparator: 1 while the integrator output is above zero |
| sw_az_o | output | 1 | Auto-zero switch control |
| sw_int_o | output | 1 | Signal-integrate switch control |
| sw_dip_o | output | 1 | De-integrate switch for a positive input |
| sw_din_o | output | 1 | De-integrate switch for a negative input |
| rd_bcd_o | output | 16 | Latched reading, four BCD digits |
| rd_neg_o | output | 1 | Latched sign, 1 for a negative input |
| rd_ovr_o | output | 1 | Latched overrange flag |
| rd_stb_o | output | 1 | One-clock strobe for a new reading |

## Verification
A zero crossing and the de-integrate count limit can land on the same tick. The design must then end de-integration only once and report the crossing, not overrange. The bench provokes this by scripting its comparator model to flip exactly 1999 counts after de-integrate starts, for both signs. It expects reading 1999 with the overrange flag clear. Scripts of 2000 and 2500 counts serve as the contrast and must report 2000 with the flag set. Auto-zero must then shrink to 997 counts in every one of these cases.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   typedef enum logic [2:0] {
      PH_PRE_INT = 3'd0,
      PH_INT     = 3'd1,
      PH_PRE_DEI = 3'd2,
      PH_DEI     = 3'd3,
      PH_PRE_AZ  = 3'd4,
      PH_AZ      = 3'd5
   } dsadc_phase_e;

endpackage

// File: rtl/dsadc_tick_div.sv
module dsadc_tick_div #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   localparam int  W        = (DIV > 1) ? $clog2(DIV) : 1;
   localparam bit  IS_POW2  = (DIV > 1) && ((DIV & (DIV - 1)) == 0);

   generate
      if (DIV < 1) begin : g_bad_div
         $error("dsadc_tick_div: DIV must be at least 1");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = &cnt_q;
      end else begin : g_modulo
         localparam logic [W-1:0] LAST = W'(DIV - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                    cnt_q <= cnt_q + 1'b1;
         end
         assign tick_o = (cnt_q == LAST);
      end
   endgenerate

   generate
      if (DIV > 1) begin : g_tick_chk
         // R2
         tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            tick_o |=> !tick_o)
            else $error("tick asserted on consecutive clocks");
      end
   endgenerate

endmodule

// File: rtl/dsadc_bcd_cnt.sv
module dsadc_bcd_cnt #(
   parameter int DIGITS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  inc_i,
   output logic [4*DIGITS-1:0]   bcd_o
);
   generate
      if (DIGITS < 1) begin : g_bad_digits
         $error("dsadc_bcd_cnt: DIGITS must be at least 1");
      end
   endgenerate

   logic [DIGITS-1:0] step;

   generate
      for (genvar i = 0; i < DIGITS; i++) begin : g_digit
         logic [3:0] dig_q;

         if (i == 0) begin : g_first
            assign step[i] = inc_i;
         end else begin : g_chain
            assign step[i] = step[i-1] & (g_digit[i-1].dig_q == 4'd9);
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       dig_q <= 4'd0;
            else if (clr_i)   dig_q <= 4'd0;
            else if (step[i]) dig_q <= (dig_q == 4'd9) ? 4'd0 : dig_q + 4'd1;
         end

         assign bcd_o[4*i +: 4] = dig_q;

         // R7
         dig_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dig_q <= 4'd9)
            else $error("BCD digit %0d out of range", i);
      end
   endgenerate

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
   import dsadc_pkg::*;
#(
   parameter int CLK_DIV      = 4,
   parameter int CYCLE_COUNTS = 4000,
   parameter int INT_COUNTS   = 1000,
   parameter int DEINT_MAX    = 2000,
   parameter int GAP_COUNTS   = 1,
   parameter int DIGITS       = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cmp_i,
   output logic                sw_az_o,
   output logic                sw_int_o,
   output logic                sw_dip_o,
   output logic                sw_din_o,
   output logic [4*DIGITS-1:0] rd_bcd_o,
   output logic                rd_neg_o,
   output logic                rd_ovr_o,
   output logic                rd_stb_o
);
   localparam int CYC_W  = $clog2(CYCLE_COUNTS);
   localparam int DCNT_W = $clog2(DEINT_MAX + 1);
   localparam int GAP_W  = $clog2(GAP_COUNTS + 1);
   localparam int BCD_W  = 4 * DIGITS;

   localparam logic [CYC_W-1:0]  CYC_LAST = CYC_W'(CYCLE_COUNTS - 1);
   localparam logic [CYC_W-1:0]  INT_LAST = CYC_W'(GAP_COUNTS + INT_COUNTS - 1);
   localparam logic [DCNT_W-1:0] DEI_LAST = DCNT_W'(DEINT_MAX - 1);
   localparam logic [GAP_W-1:0]  GAP_LAST = GAP_W'(GAP_COUNTS - 1);

   generate
      if (GAP_COUNTS < 1) begin : g_bad_gap
         $error("dsadc_seq: GAP_COUNTS must be at least 1");
      end
      if (INT_COUNTS < 1 || DEINT_MAX < 1) begin : g_bad_len
         $error("dsadc_seq: phase lengths must be positive");
      end
      if (INT_COUNTS + DEINT_MAX + 3 * GAP_COUNTS >= CYCLE_COUNTS) begin : g_bad_cycle
         $error("dsadc_seq: cycle leaves no auto-zero time");
      end
      if (DEINT_MAX >= 10 ** DIGITS) begin : g_bad_digits
         $error("dsadc_seq: DIGITS too few for DEINT_MAX");
      end
   endgenerate

   logic                tick;
   dsadc_phase_e        phase_q, gap_next;
   logic [CYC_W-1:0]    cyc_q;
   logic [GAP_W-1:0]    gap_q;
   logic [DCNT_W-1:0]   dcnt_q;
   logic                neg_q, ovr_q, fin_q;
   logic                crossed, gap_done;
   logic                bcd_clr, bcd_inc;
   logic [BCD_W-1:0]    bcd;
   logic [BCD_W-1:0]    rd_bcd_q;
   logic                rd_neg_q, rd_ovr_q, rd_stb_q;

   dsadc_tick_div #(.DIV(CLK_DIV)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick_o (tick)
   );

   assign crossed  = (cmp_i == neg_q);
   assign gap_done = (gap_q == GAP_LAST);
   assign bcd_clr  = tick && (phase_q == PH_PRE_DEI);
   assign bcd_inc  = tick && (phase_q == PH_DEI) && !crossed;

   dsadc_bcd_cnt #(.DIGITS(DIGITS)) u_bcd (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (bcd_clr),
      .inc_i (bcd_inc),
      .bcd_o (bcd)
   );

   always_comb begin
      unique case (phase_q)
         PH_PRE_INT: gap_next = PH_INT;
         PH_PRE_DEI: gap_next = PH_DEI;
         PH_PRE_AZ:  gap_next = PH_AZ;
         default:    gap_next = PH_PRE_INT;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_PRE_INT;
         cyc_q    <= '0;
         gap_q    <= '0;
         dcnt_q   <= '0;
         neg_q    <= 1'b0;
         ovr_q    <= 1'b0;
         fin_q    <= 1'b0;
         rd_bcd_q <= '0;
         rd_neg_q <= 1'b0;
         rd_ovr_q <= 1'b0;
         rd_stb_q <= 1'b0;
      end else begin
         rd_stb_q <= fin_q;
         fin_q    <= 1'b0;
         if (fin_q) begin
            rd_bcd_q <= bcd;
            rd_neg_q <= neg_q;
            rd_ovr_q <= ovr_q;
         end
         if (tick) begin
            cyc_q <= (cyc_q == CYC_LAST) ? '0 : cyc_q + 1'b1;
            unique case (phase_q)
               PH_PRE_INT, PH_PRE_AZ, PH_PRE_DEI: begin
                  if (phase_q == PH_PRE_DEI) dcnt_q <= '0;
                  if (gap_done) begin
                     gap_q   <= '0;
                     phase_q <= gap_next;
                  end else begin
                     gap_q   <= gap_q + 1'b1;
                  end
               end
               PH_INT: begin
                  if (cyc_q == INT_LAST) begin
                     phase_q <= PH_PRE_DEI;
                     neg_q   <= ~cmp_i;
                  end
               end
               PH_DEI: begin
                  if (crossed) begin
                     phase_q <= PH_PRE_AZ;
                     ovr_q   <= 1'b0;
                     fin_q   <= 1'b1;
                  end else begin
                     dcnt_q <= dcnt_q + 1'b1;
                     if (dcnt_q == DEI_LAST) begin
                        phase_q <= PH_PRE_AZ;
                        ovr_q   <= 1'b1;
                        fin_q   <= 1'b1;
                     end
                  end
               end
               PH_AZ: begin
                  if (cyc_q == CYC_LAST) phase_q <= PH_PRE_INT;
               end
               default: phase_q <= PH_PRE_INT;
            endcase
         end
      end
   end

   assign sw_az_o  = (phase_q == PH_AZ);
   assign sw_int_o = (phase_q == PH_INT);
   assign sw_dip_o = (phase_q == PH_DEI) && !neg_q;
   assign sw_din_o = (phase_q == PH_DEI) &&  neg_q;
   assign rd_bcd_o = rd_bcd_q;
   assign rd_neg_o = rd_neg_q;
   assign rd_ovr_o = rd_ovr_q;
   assign rd_stb_o = rd_stb_q;

   logic [3:0] sw_vec;
   assign sw_vec = {sw_az_o, sw_int_o, sw_dip_o, sw_din_o};

   // R4
   sw_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sw_vec))
      else $error("more than one switch closed");

   // R4
   bbm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sw_vec) != 4'b0 && sw_vec != 4'b0) |-> (sw_vec == $past(sw_vec)))
      else $error("switch change without an open interval");

   // R6
   pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_dip_o || sw_din_o) |-> $stable(neg_q))
      else $error("sign changed during de-integrate");

   // R8
   dei_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_DEI) |-> (dcnt_q < DCNT_W'(DEINT_MAX)))
      else $error("de-integrate count past limit");

   // R10
   stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_o |=> !rd_stb_o)
      else $error("strobe wider than one clock");

   // R5
   az_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(sw_az_o)) |-> (cyc_q == '0))
      else $error("auto-zero ended off the cycle boundary");

endmodule

// File: tb/dsadc_seq_tb.sv
module dsadc_seq_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmp_i = 1'b0;
   logic        sw_az_o, sw_int_o, sw_dip_o, sw_din_o;
   logic [15:0] rd_bcd_o;
   logic        rd_neg_o, rd_ovr_o, rd_stb_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   dsadc_seq u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmp_i    (cmp_i),
      .sw_az_o  (sw_az_o),
      .sw_int_o (sw_int_o),
      .sw_dip_o (sw_dip_o),
      .sw_din_o (sw_din_o),
      .rd_bcd_o (rd_bcd_o),
      .rd_neg_o (rd_neg_o),
      .rd_ovr_o (rd_ovr_o),
      .rd_stb_o (rd_stb_o)
   );

   int checks = 0;
   int errors = 0;

   typedef struct {
      logic [15:0] bcd;
      logic        neg;
      logic        ovr;
      string       req;
   } exp_t;
   exp_t exp_q[$];

   logic scr_pos = 1'b1;
   int   scr_n   = 0;
   int   dei_clk = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   function automatic logic [15:0] to_bcd(input int v);
      logic [15:0] r;
      int x;
      x = v;
      for (int i = 0; i < 4; i++) begin
         r[4*i +: 4] = 4'(x % 10);
         x = x / 10;
      end
      return r;
   endfunction

   // comparator model: integrator sign follows the input, and flips after N de-integrate counts
   always @(negedge clk) begin
      if (sw_dip_o || sw_din_o) dei_clk = dei_clk + 1;
      else                      dei_clk = 0;
      cmp_i = scr_pos ^ (dei_clk > 4 * scr_n);
   end

   // monitor
   logic [3:0] prev_sw = 4'b0;
   logic       prev_stb = 1'b0;
   int int_clk = 0, az_clk = 0, gap_clk = 0, since_dei = 100;
   int since_int = 0, int_rises = 0, last_kind = 0;

   always @(negedge clk) begin
      logic [3:0] sw;
      int kind, exp_az, nn;
      exp_t e;
      if (rst_n) begin
         sw = {sw_az_o, sw_int_o, sw_dip_o, sw_din_o};
         since_int++;
         // R2 integrate length
         if (sw_int_o) int_clk++;
         if (prev_sw[2] && !sw_int_o) begin
            chk(int_clk == 4000, "R2", "integrate clocks", int_clk, 4000);
            int_clk = 0;
         end
         // R5 auto-zero length
         if (sw_az_o) az_clk++;
         if (prev_sw[3] && !sw_az_o) begin
            nn = (scr_n < 1999) ? scr_n : 1999;
            exp_az = 4 * (2996 - nn);
            chk(az_clk == exp_az, "R5", "auto-zero clocks", az_clk, exp_az);
            az_clk = 0;
         end
         // R3 / R4 / R5 / R6 at each switch closure
         if (sw == 4'b0) gap_clk++;
         else if (prev_sw == 4'b0) begin
            kind = sw_az_o ? 1 : (sw_int_o ? 2 : 3);
            if (last_kind != 0)
               chk(gap_clk == 4, "R4", "open interval clocks", gap_clk, 4);
            chk((kind == 2 && (last_kind == 0 || last_kind == 1)) ||
                (kind == 3 && last_kind == 2) ||
                (kind == 1 && last_kind == 3),
                "R3", "phase after previous", kind, last_kind);
            if (kind == 2) begin
               if (int_rises > 0)
                  chk(since_int == 16000, "R5", "cycle clocks", since_int, 16000);
               int_rises++;
               since_int = 0;
            end
            if (kind == 3)
               chk(sw_dip_o == scr_pos, "R6", "positive de-integrate switch",
                   int'(sw_dip_o), int'(scr_pos));
            last_kind = kind;
            gap_clk = 0;
         end
         // R10 strobe timing
         if (prev_sw[1:0] != 2'b0 && sw[1:0] == 2'b0) since_dei = 0;
         else since_dei++;
         if (prev_stb)
            chk(!rd_stb_o, "R10", "strobe width", int'(rd_stb_o), 0);
         if (rd_stb_o) begin
            chk(since_dei == 1, "R10", "strobe delay after de-integrate", since_dei, 1);
            if (exp_q.size() == 0) begin
               chk(1'b0, "R10", "unexpected strobe", 1, 0);
            end else begin
               e = exp_q.pop_front();
               chk(rd_bcd_o == e.bcd, e.req, "reading bcd", int'(rd_bcd_o), int'(e.bcd));
               chk(rd_neg_o == e.neg, "R6", "sign", int'(rd_neg_o), int'(e.neg));
               chk(rd_ovr_o == e.ovr, e.req, "overrange", int'(rd_ovr_o), int'(e.ovr));
            end
         end
         prev_sw  = sw;
         prev_stb = rd_stb_o;
      end
   end

   task automatic run_conv(input bit pos, input int n, input string req);
      exp_t e;
      @(negedge clk iff sw_int_o);
      scr_pos = pos;
      scr_n   = n;
      e.bcd = (n >= 2000) ? to_bcd(2000) : to_bcd(n);
      e.ovr = (n >= 2000);
      e.neg = !pos;
      e.req = req;
      exp_q.push_back(e);
      @(negedge clk iff !sw_int_o);
   endtask

   task automatic check_idle(input string when);
      chk({sw_az_o, sw_int_o, sw_dip_o, sw_din_o} == 4'b0, "R1", {when, " switches"},
          int'({sw_az_o, sw_int_o, sw_dip_o, sw_din_o}), 0);
      chk(!rd_stb_o && rd_bcd_o == 16'h0 && !rd_neg_o && !rd_ovr_o, "R1",
          {when, " reading outputs"}, int'(rd_bcd_o), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check_idle("in reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("after reset");
      fork
         begin
            run_conv(1'b1, 500,  "R7");
            run_conv(1'b0, 1000, "R7");
            run_conv(1'b1, 0,    "R7");
            run_conv(1'b1, 1999, "R9");
            run_conv(1'b0, 2000, "R8");
            run_conv(1'b0, 1999, "R9");
            run_conv(1'b1, 2500, "R8");
            run_conv(1'b0, 37,   "R7");
            wait (exp_q.size() == 0);
            repeat (10) @(negedge clk);
         end
         begin
            repeat (190000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule